// File: doc/BRIEF.md
# SPI-Mode Card Command and Response Token Engine

This block is the card-side protocol front end of a serial flash card running in SPI mode. One clock edge carries one bit. While chip-select is low, it watches the data-in line for a 48-bit command frame and checks the frame's CRC-7 and end bit. It then decides whether the command is accepted, illegal or corrupted. Every response goes out most significant bit first on data-out, after a fixed number of all-ones filler bytes. The line stays high whenever nothing is being sent.

Before SPI mode is entered, the block reacts only to a reset command (index 0) with a correct CRC. Once that command has been seen, the block stays in SPI mode until reset. From then on it answers every frame: a one-byte status, a two-byte status, or a five-byte status-plus-operating-conditions word. Error flags supplied by an external status source are merged into the status byte. On request it also sends the one-byte token that acknowledges a written block and the one-byte token that replaces a failed read. Accepted commands are announced to the surrounding logic by a one-cycle strobe and the command index.

Top module: `spi_rsp_engine`

## Requirements
- R1: After reset, `do_o` is 1 and `cmd_valid` is 0.
- R2: Before SPI mode is entered, any frame other than index 0 with a correct CRC gives no strobe and no response bits (`do_o` stays 1).
- R3: A correctly coded index-0 frame enters SPI mode and sets the idle flag. Its response byte is 0x01. Each response starts after `FILL_BYTES` bytes of 0xFF, and the first filler bit is driven in the cycle after the strobe.
- R4: Every token is sent MSB first. In the status byte, bit 7 is 0, bit 0 is idle, bit 1 is erase-reset, bit 2 is illegal-command, bit 3 is CRC error, bit 4 is erase-sequence error, bit 5 is address error and bit 6 is parameter error.
- R5: In SPI mode, an index outside the supported set answers with only bit 2 set (plus the idle bit) and gives no strobe. Multi-block indices 18 and 25 are outside the set.
- R6: CRC checking is off on entry to SPI mode. Index 59 with argument bit 0 = 1 turns it on, and with bit 0 = 0 turns it off. While it is on, a frame with a bad CRC or end bit answers with only bit 3 set (plus idle) and gives no strobe. While it is off, such a frame is accepted.
- R7: Index 58 answers with 5 bytes: the status byte, then the operating-conditions word `OCR_BASE[30:0]`, with bit 31 equal to the inverse of the idle flag as it was before the command.
- R8: Index 13 answers with 2 bytes: the status byte, then `stat_lo`.
- R9: Index 1 sets the idle flag to the value of `init_busy`, and its own status byte already shows the new value.
- R10: On an accepted command, `ext_err[0]`, `ext_err[1]`, `ext_err[2]` and `ext_err[3]` appear in status bits 1, 4, 5 and 6. They are masked on rejected commands.
- R11: A `dresp_req` pulse while the transmitter is idle sends 0b1110_sss1, where sss = 010 for code 0 (accepted), 101 for code 1 (CRC error) and 110 for code 2 (write error).
- R12: A `derr_req` pulse while the transmitter is idle sends 0b0000 followed by `derr_bits`.
- R13: For an accepted frame, `cmd_valid` is high for exactly one cycle, the cycle after the edge that samples the last frame bit, with `cmd_idx` holding the index.
- R14: Capture starts on a 0 bit. A second bit of 0 abandons the frame, and raising `cs_n` abandons a partial frame. Neither produces a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| di | input | 1 | Serial command data in |
| do_o | output | 1 | Serial response data out, high when idle |
| init_busy | input | 1 | Initialisation still running, value taken by index 1 |
| ext_err | input | 4 | External flags {param, addr, erase-seq, erase-reset} |
| stat_lo | input | 8 | Second byte of the two-byte status response |
| dresp_req | input | 1 | Request a written-block acknowledge token |
| dresp_code | input | 2 | 0 accepted, 1 CRC error, 2 write error |
| derr_req | input | 1 | Request a read-failure token |
| derr_bits | input | 4 | Low nibble of the read-failure token |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_idx | output | 6 | Index of the command being strobed |

## Verification
Let edge k be the edge that samples the last frame bit. The strobe is due in the half cycle after edge k. The transmitter loads at edge k+1, so token bit t is on `do_o` after edge k+1+8·FILL_BYTES+t. The bench therefore reads the strobe at the falling edge after edge k, skips 1+8·FILL_BYTES falling edges, and then takes one bit per falling edge. A data token requested at a falling edge follows the same count, because it loads at the next rising edge. A bench model of the idle flag and the CRC switch gives the expected bytes for both the random and the directed frames.

// File: rtl/spi_rsp_pkg.sv
package spi_rsp_pkg;

    localparam int FRAME_W = 48;
    localparam int TOK_W   = 40;

    localparam logic [5:0] IDX_RESET  = 6'd0;
    localparam logic [5:0] IDX_INIT   = 6'd1;
    localparam logic [5:0] IDX_STATUS = 6'd13;
    localparam logic [5:0] IDX_OCR    = 6'd58;
    localparam logic [5:0] IDX_CRCSW  = 6'd59;

    typedef struct packed {
        logic [5:0] idx;
        logic       arg0;
        logic       crc_ok;
    } cmd_t;

    typedef struct packed {
        logic [TOK_W-1:0] bytes;
        logic [2:0]       len;
    } tok_t;

    function automatic logic [6:0] crc7(input logic [39:0] d);
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            fb = d[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic idx_supported(input logic [5:0] idx);
        case (idx)
            6'd0, 6'd1, 6'd9, 6'd10, 6'd12, 6'd13, 6'd16, 6'd17, 6'd24,
            6'd27, 6'd28, 6'd29, 6'd30, 6'd32, 6'd33, 6'd34, 6'd35,
            6'd36, 6'd37, 6'd38, 6'd42, 6'd58, 6'd59: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] dresp_byte(input logic [1:0] code);
        logic [2:0] s;
        case (code)
            2'd0:    s = 3'b010;
            2'd1:    s = 3'b101;
            default: s = 3'b110;
        endcase
        return {3'b111, 1'b0, s, 1'b1};
    endfunction

endpackage

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
    import spi_rsp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic di,
    output logic done,
    output cmd_t cmd
);
    localparam int CW = $clog2(FRAME_W);

    logic               capt;
    logic [CW-1:0]      cnt;
    logic [FRAME_W-1:0] sr;
    logic [FRAME_W-1:0] full;

    assign full = {sr[FRAME_W-2:0], di};

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            capt <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
            sr   <= '0;
            if (rst) cmd <= '0;
        end else begin
            done <= 1'b0;
            if (!capt) begin
                if (!di) begin
                    capt <= 1'b1;
                    cnt  <= CW'(1);
                    sr   <= '0;
                end
            end else begin
                sr  <= full;
                cnt <= cnt + CW'(1);
                if (cnt == CW'(1) && !di) begin
                    capt <= 1'b0;
                end else if (cnt == CW'(FRAME_W - 1)) begin
                    capt       <= 1'b0;
                    done       <= 1'b1;
                    cmd.idx    <= full[45:40];
                    cmd.arg0   <= full[8];
                    cmd.crc_ok <= (crc7(full[47:8]) == full[7:1]) && full[0];
                end
            end
        end
    end

    p_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_abort_r14: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !done);

endmodule

// File: rtl/spi_tok_tx.sv
module spi_tok_tx
    import spi_rsp_pkg::*;
#(
    parameter int FILL_BYTES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic load,
    input  tok_t tok,
    output logic busy,
    output logic do_o
);
    localparam int TXW = 8 * FILL_BYTES + TOK_W;
    localparam int CW  = $clog2(TXW + 1);

    logic [TXW-1:0] sr;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '1;
            cnt <= '0;
        end else if (load) begin
            sr  <= {{(8*FILL_BYTES){1'b1}}, tok.bytes};
            cnt <= CW'(8 * FILL_BYTES) + CW'({tok.len, 3'b000});
        end else if (cnt != '0) begin
            sr  <= {sr[TXW-2:0], 1'b1};
            cnt <= cnt - CW'(1);
        end
    end

    assign busy = (cnt != '0);
    assign do_o = cs_n ? 1'b1 : (busy ? sr[TXW-1] : 1'b1);

    p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
        busy && !load |=> cnt == $past(cnt) - CW'(1));
    p_filler_first_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> busy && sr[TXW-1]);

endmodule

// File: rtl/spi_rsp_engine.sv
module spi_rsp_engine
    import spi_rsp_pkg::*;
#(
    parameter int          FILL_BYTES = 1,
    parameter logic [31:0] OCR_BASE   = 32'h00FF8000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       di,
    output logic       do_o,
    input  logic       init_busy,
    input  logic [3:0] ext_err,
    input  logic [7:0] stat_lo,
    input  logic       dresp_req,
    input  logic [1:0] dresp_code,
    input  logic       derr_req,
    input  logic [3:0] derr_bits,
    output logic       cmd_valid,
    output logic [5:0] cmd_idx
);
    logic done;
    cmd_t cmd;
    logic busy;
    logic load;
    tok_t tok;

    logic in_spi, idle, crc_en;
    logic respond, rej_crc, rej_ill, accept, idle_nxt;
    logic [3:0] err_m;
    logic [7:0] r1;

    spi_cmd_rx i_rx (
        .clk(clk), .rst(rst), .cs_n(cs_n), .di(di), .done(done), .cmd(cmd)
    );

    spi_tok_tx #(.FILL_BYTES(FILL_BYTES)) i_tx (
        .clk(clk), .rst(rst), .cs_n(cs_n), .load(load), .tok(tok),
        .busy(busy), .do_o(do_o)
    );

    always_comb begin
        respond  = done && (in_spi || (cmd.idx == IDX_RESET && cmd.crc_ok));
        rej_crc  = in_spi && crc_en && !cmd.crc_ok;
        rej_ill  = in_spi && !rej_crc && !idx_supported(cmd.idx);
        accept   = respond && !rej_crc && !rej_ill;
        idle_nxt = idle;
        if (accept && cmd.idx == IDX_RESET) idle_nxt = 1'b1;
        if (accept && cmd.idx == IDX_INIT)  idle_nxt = init_busy;
        err_m = accept ? ext_err : 4'b0000;
        r1    = {1'b0, err_m[3], err_m[2], err_m[1], rej_crc, rej_ill, err_m[0], idle_nxt};

        tok = '{bytes: {r1, 32'hFFFF_FFFF}, len: 3'd1};
        if (respond) begin
            if (accept && cmd.idx == IDX_STATUS)
                tok = '{bytes: {r1, stat_lo, 24'hFF_FFFF}, len: 3'd2};
            else if (accept && cmd.idx == IDX_OCR)
                tok = '{bytes: {r1, ~idle, OCR_BASE[30:0]}, len: 3'd5};
        end else if (dresp_req) begin
            tok = '{bytes: {dresp_byte(dresp_code), 32'hFFFF_FFFF}, len: 3'd1};
        end else begin
            tok = '{bytes: {4'b0000, derr_bits, 32'hFFFF_FFFF}, len: 3'd1};
        end
        load = respond || (!busy && (dresp_req || derr_req));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_spi <= 1'b0;
            idle   <= 1'b0;
            crc_en <= 1'b0;
        end else if (done) begin
            if (accept && cmd.idx == IDX_RESET) in_spi <= 1'b1;
            idle <= idle_nxt;
            if (accept && cmd.idx == IDX_CRCSW) crc_en <= cmd.arg0;
        end
    end

    assign cmd_valid = accept;
    assign cmd_idx   = cmd.idx;

    p_r1_msb_r4: assert property (@(posedge clk) disable iff (rst)
        respond |-> !tok.bytes[TOK_W-1]);
    p_no_strobe_premode_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (in_spi || cmd_idx == IDX_RESET));
    p_crc_reject_r6: assert property (@(posedge clk) disable iff (rst)
        done && in_spi && crc_en && !cmd.crc_ok |-> !cmd_valid);
    p_mode_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        in_spi |=> in_spi);

endmodule

// File: tb/test_spi_rsp_engine.sv
module test_spi_rsp_engine;
    localparam int FILL = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, di = 1'b1;
    logic do_o;
    logic init_busy = 1'b0;
    logic [3:0] ext_err = '0;
    logic [7:0] stat_lo = '0;
    logic dresp_req = 1'b0, derr_req = 1'b0;
    logic [1:0] dresp_code = '0;
    logic [3:0] derr_bits = '0;
    logic cmd_valid;
    logic [5:0] cmd_idx;

    int n_vec = 0, n_bad = 0, cyc = 0;
    bit m_idle = 0, m_crc = 0;

    always #10 clk = ~clk;

    spi_rsp_engine #(.FILL_BYTES(FILL)) i_spi_rsp_engine (
        .clk(clk), .rst(rst), .cs_n(cs_n), .di(di), .do_o(do_o),
        .init_busy(init_busy), .ext_err(ext_err), .stat_lo(stat_lo),
        .dresp_req(dresp_req), .dresp_code(dresp_code),
        .derr_req(derr_req), .derr_bits(derr_bits),
        .cmd_valid(cmd_valid), .cmd_idx(cmd_idx)
    );

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            finish_run();
        end
    end

    function automatic logic [6:0] tb_crc(input logic [39:0] d);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic fb = d[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic bit tb_legal(input int i);
        return i inside {0, 1, 9, 10, 12, 13, 16, 17, 24, 27, 28, 29, 30,
                         32, 33, 34, 35, 36, 37, 38, 42, 58, 59};
    endfunction

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [47:0] f, input int n);
        for (int i = 47; i > 47 - n; i--) begin
            @(negedge clk); di = f[i];
        end
        @(posedge clk);
        @(negedge clk); di = 1'b1;
    endtask

    task automatic send(input int idx, input logic [31:0] arg, input bit bad);
        logic [39:0] h = {2'b01, 6'(idx), arg};
        logic [6:0] c = tb_crc(h) ^ (bad ? 7'h11 : 7'h00);
        send_bits({h, c, 1'b1}, 48);
    endtask

    task automatic get_bytes(input int n, output logic [39:0] v);
        v = '1;
        repeat (1 + 8 * FILL) @(negedge clk);
        for (int b = 0; b < 8 * n; b++) begin
            if (b != 0) @(negedge clk);
            v = {v[38:0], do_o};
        end
        v = v << (40 - 8 * n);
        v = v | ~({40{1'b1}} << (40 - 8 * n));
    endtask

    task automatic cmd_check(input string req, input int idx, input logic [31:0] arg,
                             input bit bad, input bit exp_v, input int n,
                             input logic [39:0] exp);
        logic [39:0] v;
        send(idx, arg, bad);
        chk({req, " strobe"}, {39'b0, cmd_valid}, {39'b0, exp_v});
        if (exp_v) chk({req, " index"}, {34'b0, cmd_idx}, 40'(idx));
        get_bytes(n, v);
        chk(req, v, exp);
    endtask

    task automatic data_tok(input string req, input bit isresp, input logic [39:0] exp);
        logic [39:0] v;
        @(negedge clk);
        if (isresp) dresp_req = 1'b1; else derr_req = 1'b1;
        fork
            get_bytes(1, v);
            begin @(negedge clk); dresp_req = 1'b0; derr_req = 1'b0; end
        join
        chk(req, v, exp);
    endtask

    initial begin
        logic [39:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset do", {39'b0, do_o}, 40'd1);
        chk("R1 reset strobe", {39'b0, cmd_valid}, 40'd0);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);

        cmd_check("R2 premode cmd17", 17, 0, 0, 0, 2, {16'hFFFF, 24'hFFFFFF});
        cmd_check("R2 premode bad cmd0", 0, 0, 1, 0, 2, {16'hFFFF, 24'hFFFFFF});

        send_bits({2'b00, 46'h3FFF_FFFF_FFFF}, 20);
        get_bytes(2, v);
        chk("R14 second bit zero", v, 40'hFF_FFFF_FFFF);
        send_bits({2'b01, 6'd0, 32'd0, tb_crc({2'b01, 6'd0, 32'd0}), 1'b1}, 20);
        @(negedge clk); cs_n = 1'b1; @(negedge clk); cs_n = 1'b0;
        get_bytes(2, v);
        chk("R14 cs abort", v, 40'hFF_FFFF_FFFF);

        cmd_check("R3 enter mode", 0, 0, 0, 1, 1, {8'h01, 32'hFFFF_FFFF});
        m_idle = 1;
        init_busy = 1'b1;
        cmd_check("R9 init busy", 1, 0, 0, 1, 1, {8'h01, 32'hFFFF_FFFF});
        cmd_check("R7 ocr while idle", 58, 0, 0, 1, 5, {8'h01, 32'h00FF8000});
        init_busy = 1'b0;
        cmd_check("R9 init done", 1, 0, 0, 1, 1, {8'h00, 32'hFFFF_FFFF});
        m_idle = 0;
        cmd_check("R7 ocr ready", 58, 0, 0, 1, 5, {8'h00, 32'h80FF8000});
        stat_lo = 8'hA5;
        cmd_check("R8 status", 13, 0, 0, 1, 2, {16'h00A5, 24'hFFFFFF});
        cmd_check("R5 cmd18", 18, 0, 0, 0, 1, {8'h04, 32'hFFFF_FFFF});
        cmd_check("R5 cmd25", 25, 0, 0, 0, 1, {8'h04, 32'hFFFF_FFFF});
        cmd_check("R6 crc off bad", 16, 512, 1, 1, 1, {8'h00, 32'hFFFF_FFFF});
        cmd_check("R6 crc on", 59, 1, 0, 1, 1, {8'h00, 32'hFFFF_FFFF});
        cmd_check("R6 crc on bad", 16, 512, 1, 0, 1, {8'h08, 32'hFFFF_FFFF});
        cmd_check("R6 crc off", 59, 0, 0, 1, 1, {8'h00, 32'hFFFF_FFFF});
        cmd_check("R6 crc off again", 17, 0, 1, 1, 1, {8'h00, 32'hFFFF_FFFF});
        ext_err = 4'hF;
        cmd_check("R10 all ext", 16, 8, 0, 1, 1, {8'h72, 32'hFFFF_FFFF});
        ext_err = 4'b0101;
        cmd_check("R10 some ext", 16, 8, 0, 1, 1, {8'h22, 32'hFFFF_FFFF});
        cmd_check("R10 masked on reject", 18, 0, 0, 0, 1, {8'h04, 32'hFFFF_FFFF});
        ext_err = 4'h0;
        cmd_check("R4 reenter idle", 0, 0, 0, 1, 1, {8'h01, 32'hFFFF_FFFF});
        m_idle = 1;

        dresp_code = 2'd0; data_tok("R11 accepted", 1, {8'hE5, 32'hFFFF_FFFF});
        dresp_code = 2'd1; data_tok("R11 crc", 1, {8'hEB, 32'hFFFF_FFFF});
        dresp_code = 2'd2; data_tok("R11 write", 1, {8'hED, 32'hFFFF_FFFF});
        derr_bits = 4'hA;  data_tok("R12 read error", 0, {8'h0A, 32'hFFFF_FFFF});

        for (int it = 0; it < 40; it++) begin
            int idx;
            bit bad, rc, ri, acc, nid;
            logic [3:0] e;
            logic [7:0] r1, st;
            logic [31:0] arg;
            logic [39:0] exp;
            int n;
            idx = (it % 5 == 0) ? 59 : int'($urandom % 64);
            bad = ($urandom % 4) == 0;
            arg = $urandom;
            e   = 4'($urandom);
            st  = 8'($urandom);
            ext_err = e; stat_lo = st;
            rc  = m_crc && bad;
            ri  = !rc && !tb_legal(idx);
            acc = !rc && !ri;
            nid = m_idle;
            if (acc && idx == 0) nid = 1;
            if (acc && idx == 1) nid = 0;
            if (!acc) e = 0;
            r1 = {1'b0, e[3], e[2], e[1], rc, ri, e[0], nid};
            n = 1; exp = {r1, 32'hFFFF_FFFF};
            if (acc && idx == 13) begin n = 2; exp = {r1, st, 24'hFFFFFF}; end
            if (acc && idx == 58) begin n = 5; exp = {r1, ~m_idle, 31'h00FF8000}; end
            cmd_check("R4 R5 R6 R10 random", idx, arg, bad, acc, n, exp);
            m_idle = nid;
            if (acc && idx == 59) m_crc = arg[0];
        end
        finish_run();
    end
endmodule